// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from normal execution into an exception or interrupt handler. A request arrives with one of four causes: a software break, a non-maskable interrupt, a bus fault, or an external interrupt. The core's live context comes with it: program counter, pending delay-slot size, flag register, stack pointer, kernel stack pointer, vector base and the three candidate vector numbers. The block takes a snapshot of that context when it accepts the request. It picks the vector number and reads the handler address from a vector table in memory through a one-request read port. It then hands back the complete updated context in a single commit.

At commit the block produces the following:
- the new PC;
- the return address, with a write strobe that selects either the exception return register or the NMI return register;
- a cause status word;
- the pushed flag register;
- the stack-pointer swap, when the core was in user mode;
- a delay-slot clear strobe.

Both strobes and `done` pulse for one cycle, and the core applies all of these values in that cycle. A bus fault request that arrives while a bus fault is already being handled raises `abort`.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause code 0 (break) uses `trap_vec` as the vector and saves the return address through `ret_we_exc`.
- R2: Cause code 1 (non-maskable) uses vector 0 and saves the return address through `ret_we_nmi`, never through `ret_we_exc`. It also clears flag bit 9 (the nmi-enable bit) before the flag push, so that bit arrives at position 19 as zero.
- R3: Cause code 2 (bus fault) uses `fault_vec` and saves the return address through `ret_we_exc`.
- R4: Cause code 3 (external interrupt) uses `irq_vec` and saves the return address through `ret_we_exc`.
- R5: `cause_word` holds the 8-bit vector in bits 15:8, and every other bit is zero.
- R6: `ret_addr` equals the snapshot PC minus `dslot_size`, computed modulo 2^32. `dslot_clr` pulses with `done` exactly when `dslot_size` was nonzero.
- R7: The table read address is `vbase + 4*vector`, computed modulo 2^32. `mem_req_valid` and `mem_addr` hold steady until `mem_req_ready`. `new_pc` equals the `mem_rdata` returned with `mem_rvalid`.
- R8: If flag bit 6 (user mode) was set in the snapshot, `usp_we` pulses, `usp_val` equals the snapshot stack pointer, and `sp_val` equals `ksp_in`. Otherwise `usp_we` stays low and `sp_val` equals the snapshot stack pointer.
- R9: `flag_val` keeps input bits 31:30 in place, carries input bits 19:0 into bits 29:10, and has bits 9:0 clear. This clears the user-mode bit.
- R10: `done` is high for exactly one cycle, in the cycle after `mem_rvalid`. Exactly one return-address strobe is high with it, and all result ports change in that same cycle.
- R11: While `busy` is high, a request is not accepted. Its cause and context have no effect on the results of the sequence in flight.
- R12: A cause-2 request that arrives while a cause-2 sequence is busy raises `abort` for one cycle in the following cycle. A request of any other pairing does not.
- R13: After reset, `busy`, `mem_req_valid`, `done`, all strobes and `abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request |
| req_cause | input | 2 | 0 break, 1 non-maskable, 2 bus fault, 3 external interrupt |
| trap_vec | input | 8 | Programmable break vector |
| fault_vec | input | 8 | Vector latched by a failed translation |
| irq_vec | input | 8 | Vector from the interrupt controller |
| cur_pc | input | 32 | Current program counter |
| dslot_size | input | 2 | Pending delay-slot size in bytes, 0 if none |
| flag_in | input | 32 | Current flag register |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Saved kernel stack pointer |
| vbase | input | 32 | Vector table base address |
| busy | output | 1 | Sequence in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read accepted |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle commit pulse |
| new_pc | output | 32 | Handler address |
| ret_addr | output | 32 | Return address to save |
| ret_we_exc | output | 1 | Write return address to the exception return register |
| ret_we_nmi | output | 1 | Write return address to the NMI return register |
| cause_word | output | 32 | Status word carrying the vector |
| flag_val | output | 32 | Pushed flag register |
| usp_val | output | 32 | Value for the user stack pointer register |
| usp_we | output | 1 | Write strobe for the user stack pointer register |
| sp_val | output | 32 | New stack pointer |
| dslot_clr | output | 1 | Clear the delay-slot state |
| abort | output | 1 | Nested bus fault, fatal |

## Verification
The hardest situation to reach from the ports is the nested bus fault. It needs a second cause-2 request while the first sequence is still waiting on the table read, and `abort` must not fire when the two causes are mixed. The bench holds `mem_req_ready` low, which keeps a bus-fault sequence parked in its request phase. While the sequence is parked, the bench issues a cause-2 request and then a cause-3 request and checks `abort` on each following cycle. It then checks a bus fault request that arrives during a break sequence. In the same way, it changes every context input during a parked break sequence to show that the snapshot, and not the live inputs, reaches the results.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XW = 32;
  localparam int VW = 8;

  typedef enum logic [1:0] {
    CAUSE_BRK  = 2'd0,
    CAUSE_NMI  = 2'd1,
    CAUSE_BUSF = 2'd2,
    CAUSE_IRQ  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_e;

  // Flag push: top two bits stay, low twenty move up by ten, low ten clear.
  function automatic logic [XW-1:0] flag_push(input logic [XW-1:0] f);
    flag_push = {f[XW-1:XW-2], f[XW-13:0], 10'b0};
  endfunction

  // Status word: vector in bits 15:8, all else zero.
  function automatic logic [XW-1:0] status_word(input logic [VW-1:0] v);
    status_word = {{(XW-VW-8){1'b0}}, v, 8'h00};
  endfunction

  // Table slot address: base plus four bytes per vector.
  function automatic logic [XW-1:0] slot_addr(input logic [XW-1:0] base,
                                               input logic [VW-1:0] v);
    slot_addr = base + {{(XW-VW-2){1'b0}}, v, 2'b00};
  endfunction

  // Return address wound back over a pending delay slot.
  function automatic logic [XW-1:0] rewind(input logic [XW-1:0] pc,
                                           input logic [XW-1:0] ds);
    rewind = pc - ds;
  endfunction
endpackage

// File: rtl/exc_vec_select.sv
module exc_vec_select
  import exc_entry_pkg::*;
(
  input  cause_e          cause,
  input  logic [VW-1:0]   trap_vec,
  input  logic [VW-1:0]   fault_vec,
  input  logic [VW-1:0]   irq_vec,
  input  logic [XW-1:0]   base,
  output logic [VW-1:0]   vec,
  output logic            to_nmi_reg,
  output logic [XW-1:0]   tbl_addr
);
  always_comb begin
    to_nmi_reg = 1'b0;
    unique case (cause)
      CAUSE_BRK:  vec = trap_vec;
      CAUSE_NMI: begin
        vec        = '0;
        to_nmi_reg = 1'b1;
      end
      CAUSE_BUSF: vec = fault_vec;
      default:    vec = irq_vec;
    endcase
  end

  assign tbl_addr = slot_addr(base, vec);
endmodule

// File: rtl/exc_ctx_update.sv
module exc_ctx_update
  import exc_entry_pkg::*;
#(
  parameter int U_BIT = 6,
  parameter int M_BIT = 9,
  parameter int DS_W  = 2
) (
  input  cause_e          cause,
  input  logic [VW-1:0]   vec,
  input  logic [XW-1:0]   pc,
  input  logic [DS_W-1:0] dslot,
  input  logic [XW-1:0]   flags,
  input  logic [XW-1:0]   sp,
  input  logic [XW-1:0]   ksp,
  output logic [XW-1:0]   ret_addr,
  output logic [XW-1:0]   status,
  output logic [XW-1:0]   flags_next,
  output logic            swap,
  output logic [XW-1:0]   usp_next,
  output logic [XW-1:0]   sp_next,
  output logic            ds_clr
);
  logic [XW-1:0] flags_m;

  always_comb begin
    flags_m = flags;
    if (cause == CAUSE_NMI) flags_m[M_BIT] = 1'b0;
  end

  assign flags_next = flag_push(flags_m);
  assign status     = status_word(vec);
  assign ret_addr   = rewind(pc, XW'(dslot));
  assign ds_clr     = |dslot;
  assign swap       = flags[U_BIT];
  assign usp_next   = sp;
  assign sp_next    = swap ? ksp : sp;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int U_BIT = 6,
  parameter int M_BIT = 9,
  parameter int DS_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_cause,
  input  logic [VW-1:0]   trap_vec,
  input  logic [VW-1:0]   fault_vec,
  input  logic [VW-1:0]   irq_vec,
  input  logic [XW-1:0]   cur_pc,
  input  logic [DS_W-1:0] dslot_size,
  input  logic [XW-1:0]   flag_in,
  input  logic [XW-1:0]   sp_in,
  input  logic [XW-1:0]   ksp_in,
  input  logic [XW-1:0]   vbase,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [XW-1:0]   mem_rdata,
  output logic            done,
  output logic [XW-1:0]   new_pc,
  output logic [XW-1:0]   ret_addr,
  output logic            ret_we_exc,
  output logic            ret_we_nmi,
  output logic [XW-1:0]   cause_word,
  output logic [XW-1:0]   flag_val,
  output logic [XW-1:0]   usp_val,
  output logic            usp_we,
  output logic [XW-1:0]   sp_val,
  output logic            dslot_clr,
  output logic            abort
);
  seq_st_e         st_q;
  cause_e          cause_q;
  logic [VW-1:0]   vec_q;
  logic            to_nmi_q;
  logic [XW-1:0]   addr_q, pc_q, flags_q, sp_q, ksp_q;
  logic [DS_W-1:0] ds_q;

  // Named internal events
  logic accept, addr_hs, commit, nested_bf;
  logic [VW-1:0] vec_sel;
  logic          to_nmi_sel;
  logic [XW-1:0] addr_sel;
  logic [XW-1:0] c_ret, c_status, c_flags, c_usp, c_sp;
  logic          c_swap, c_dsclr;

  assign busy      = (st_q != ST_IDLE);
  assign accept    = req_valid && !busy;
  assign addr_hs   = (st_q == ST_FETCH) && mem_req_ready;
  assign commit    = (st_q == ST_WAIT) && mem_rvalid;
  assign nested_bf = req_valid && busy && (cause_e'(req_cause) == CAUSE_BUSF)
                     && (cause_q == CAUSE_BUSF);

  exc_vec_select u_sel (
    .cause      (cause_e'(req_cause)),
    .trap_vec   (trap_vec),
    .fault_vec  (fault_vec),
    .irq_vec    (irq_vec),
    .base       (vbase),
    .vec        (vec_sel),
    .to_nmi_reg (to_nmi_sel),
    .tbl_addr   (addr_sel)
  );

  exc_ctx_update #(.U_BIT(U_BIT), .M_BIT(M_BIT), .DS_W(DS_W)) u_ctx (
    .cause      (cause_q),
    .vec        (vec_q),
    .pc         (pc_q),
    .dslot      (ds_q),
    .flags      (flags_q),
    .sp         (sp_q),
    .ksp        (ksp_q),
    .ret_addr   (c_ret),
    .status     (c_status),
    .flags_next (c_flags),
    .swap       (c_swap),
    .usp_next   (c_usp),
    .sp_next    (c_sp),
    .ds_clr     (c_dsclr)
  );

  // Sequencer and context snapshot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cause_q  <= CAUSE_BRK;
      vec_q    <= '0;
      to_nmi_q <= 1'b0;
      addr_q   <= '0;
      pc_q     <= '0;
      flags_q  <= '0;
      sp_q     <= '0;
      ksp_q    <= '0;
      ds_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q     <= ST_FETCH;
          cause_q  <= cause_e'(req_cause);
          vec_q    <= vec_sel;
          to_nmi_q <= to_nmi_sel;
          addr_q   <= addr_sel;
          pc_q     <= cur_pc;
          flags_q  <= flag_in;
          sp_q     <= sp_in;
          ksp_q    <= ksp_in;
          ds_q     <= dslot_size;
        end
        ST_FETCH: if (addr_hs) st_q <= ST_WAIT;
        ST_WAIT:  if (commit)  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == ST_FETCH);
  assign mem_addr      = addr_q;

  // Commit: every result lands in one cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      new_pc     <= '0;
      ret_addr   <= '0;
      ret_we_exc <= 1'b0;
      ret_we_nmi <= 1'b0;
      cause_word <= '0;
      flag_val   <= '0;
      usp_val    <= '0;
      usp_we     <= 1'b0;
      sp_val     <= '0;
      dslot_clr  <= 1'b0;
      abort      <= 1'b0;
    end else begin
      done       <= commit;
      ret_we_exc <= commit && !to_nmi_q;
      ret_we_nmi <= commit && to_nmi_q;
      usp_we     <= commit && c_swap;
      dslot_clr  <= commit && c_dsclr;
      abort      <= nested_bf;
      if (commit) begin
        new_pc     <= mem_rdata;
        ret_addr   <= c_ret;
        cause_word <= c_status;
        flag_val   <= c_flags;
        usp_val    <= c_usp;
        sp_val     <= c_sp;
      end
    end
  end

  // Assertions
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr))
    else $error("table request dropped or address moved");

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  p_one_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({ret_we_exc, ret_we_nmi}) == 1)
    else $error("return strobe count wrong");

  p_status_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cause_word[31:16] == '0) && (cause_word[7:0] == '0))
    else $error("status word has stray bits");

  p_nmi_vec0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ret_we_nmi |-> (cause_word[15:8] == '0) && !flag_val[M_BIT+10])
    else $error("non-maskable entry not on vector 0 or mask bit kept");

  p_flags_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flag_val[9:0] == '0)
    else $error("pushed flags low bits not clear");

  p_abort_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(busy))
    else $error("abort while idle");

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid)
    else $error("table request while idle");

  p_done_from_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy))
    else $error("done without a sequence");
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int CLK_P = 10;
  localparam logic [7:0]  TV = 8'h12, FV = 8'h2C, IV = 8'hF3;
  localparam logic [31:0] SPV = 32'h1000_0F00, KSPV = 32'h2000_0800;

  typedef struct packed {
    logic [1:0]  cause;
    logic [1:0]  ds;
    logic [1:0]  lat;
    logic [31:0] flags;
    logic [31:0] pc;
    logic [31:0] base;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{2'd0, 2'd0, 2'd0, 32'h0000_0040, 32'h4000_0100, 32'h8000_0000},
    '{2'd1, 2'd0, 2'd1, 32'hC000_0200, 32'h4000_0200, 32'h8000_1000},
    '{2'd2, 2'd2, 2'd2, 32'h0008_0241, 32'h4000_0302, 32'h0000_2000},
    '{2'd3, 2'd0, 2'd0, 32'h4003_FFFF, 32'h1234_5678, 32'hFFFF_FF00},
    '{2'd0, 2'd2, 2'd3, 32'h0000_0000, 32'h0000_0000, 32'h0000_0010},
    '{2'd1, 2'd2, 2'd0, 32'hFFFF_FFFF, 32'h5000_0010, 32'h0000_0000},
    '{2'd3, 2'd1, 2'd1, 32'h8000_0001, 32'h6000_0004, 32'h2000_0000},
    '{2'd2, 2'd0, 2'd0, 32'h0000_0040, 32'h7000_0000, 32'h3000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cause = '0;
  logic [7:0] trap_vec = TV, fault_vec = FV, irq_vec = IV;
  logic [31:0] cur_pc = '0, flag_in = '0, sp_in = SPV, ksp_in = KSPV, vbase = '0;
  logic [1:0] dslot_size = '0;
  logic mem_req_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic busy, mem_req_valid, done, ret_we_exc, ret_we_nmi, usp_we, dslot_clr, abort;
  logic [31:0] mem_addr, new_pc, ret_addr, cause_word, flag_val, usp_val, sp_val;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_entry_seq dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(input logic [1:0] c);
    case (c)
      2'd0: return TV;
      2'd1: return 8'h00;
      2'd2: return FV;
      default: return IV;
    endcase
  endfunction

  function automatic logic [31:0] exp_flags(input logic [1:0] c, input logic [31:0] f);
    logic [31:0] m = f;
    if (c == 2'd1) m = m & ~32'h0000_0200;
    return (m & 32'hC000_0000) | ((m & 32'h000F_FFFF) << 10);
  endfunction

  function automatic logic [31:0] handler(input logic [31:0] a);
    return a ^ 32'hC3C3_0000;
  endfunction

  task automatic issue(input logic [1:0] c, input logic [1:0] ds,
                       input logic [31:0] f, input logic [31:0] pc, input logic [31:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_cause = c; dslot_size = ds;
    flag_in = f; cur_pc = pc; vbase = b; sp_in = SPV; ksp_in = KSPV;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic serve(input int lat);
    repeat (lat) @(negedge clk);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rvalid = 1'b1;
    mem_rdata = handler(mem_addr);
    @(negedge clk);
    mem_rvalid = 1'b0;
  endtask

  // Check the commit cycle (called at the negedge where done is high).
  task automatic check_commit(input logic [1:0] c, input logic [1:0] ds,
                              input logic [31:0] f, input logic [31:0] pc,
                              input logic [31:0] b);
    logic [7:0]  v = exp_vec(c);
    logic [31:0] a = b + {22'd0, v, 2'b00};
    bit sw = f[6];
    chk("R10 done pulse", {31'd0, done}, 32'd1);
    chk("R7 new_pc from table", new_pc, handler(a));
    chk("R6 return address rewind", ret_addr, pc - {30'd0, ds});
    chk("R6 dslot_clr", {31'd0, dslot_clr}, {31'd0, ds != 2'd0});
    chk("R1/R3/R4 exc return strobe", {31'd0, ret_we_exc}, {31'd0, c != 2'd1});
    chk("R2 nmi return strobe", {31'd0, ret_we_nmi}, {31'd0, c == 2'd1});
    chk("R5 status word", cause_word, {16'd0, v, 8'd0});
    chk("R9 flag push", flag_val, exp_flags(c, f));
    chk("R8 usp strobe", {31'd0, usp_we}, {31'd0, sw});
    chk("R8 sp value", sp_val, sw ? KSPV : SPV);
    if (sw) chk("R8 usp value", usp_val, SPV);
  endtask

  task automatic check_after();
    @(negedge clk);
    chk("R10 done falls", {31'd0, done}, 32'd0);
    chk("R10 busy clear", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 busy", {31'd0, busy}, 32'd0);
    chk("R13 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R13 done", {31'd0, done}, 32'd0);
    chk("R13 strobes", {28'd0, ret_we_exc, ret_we_nmi, usp_we, dslot_clr}, 32'd0);
    chk("R13 abort", {31'd0, abort}, 32'd0);

    // Vector table walk
    for (int i = 0; i < 8; i++) begin
      issue(TBL[i].cause, TBL[i].ds, TBL[i].flags, TBL[i].pc, TBL[i].base);
      chk("R7 request valid", {31'd0, mem_req_valid}, 32'd1);
      chk("R7 table address", mem_addr,
          TBL[i].base + {22'd0, exp_vec(TBL[i].cause), 2'b00});
      serve(int'(TBL[i].lat));
      check_commit(TBL[i].cause, TBL[i].ds, TBL[i].flags, TBL[i].pc, TBL[i].base);
      check_after();
    end

    // R11: a request while busy changes nothing
    issue(2'd0, 2'd1, 32'h0000_0040, 32'h0ABC_0010, 32'h0000_4000);
    req_valid = 1'b1; req_cause = 2'd1; dslot_size = 2'd0;
    flag_in = 32'hFFFF_FFFF; cur_pc = 32'h9999_0000; vbase = 32'h7777_0000;
    sp_in = 32'h5555_5555; ksp_in = 32'h6666_6666;
    @(negedge clk);
    chk("R11 address held", mem_addr, 32'h0000_4000 + {22'd0, TV, 2'b00});
    chk("R12 no abort on other pairing", {31'd0, abort}, 32'd0);
    sp_in = SPV; ksp_in = KSPV;
    serve(1);
    req_valid = 1'b0;
    check_commit(2'd0, 2'd1, 32'h0000_0040, 32'h0ABC_0010, 32'h0000_4000);
    check_after();

    // R12: nested bus fault
    issue(2'd2, 2'd0, 32'h0, 32'h0000_8000, 32'h0001_0000);
    req_valid = 1'b1; req_cause = 2'd2;
    @(negedge clk);
    chk("R12 abort on nested bus fault", {31'd0, abort}, 32'd1);
    req_cause = 2'd3;
    @(negedge clk);
    chk("R12 abort falls for interrupt request", {31'd0, abort}, 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12 abort low when idle request gone", {31'd0, abort}, 32'd0);
    serve(0);
    check_commit(2'd2, 2'd0, 32'h0, 32'h0000_8000, 32'h0001_0000);
    check_after();

    // R12: bus fault during a break sequence does not abort
    issue(2'd0, 2'd0, 32'h0, 32'h0000_9000, 32'h0002_0000);
    req_valid = 1'b1; req_cause = 2'd2;
    @(negedge clk);
    chk("R12 no abort during break", {31'd0, abort}, 32'd0);
    req_valid = 1'b0;
    serve(0);
    check_commit(2'd0, 2'd0, 32'h0, 32'h0000_9000, 32'h0002_0000);
    check_after();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule